// File: doc/BRIEF.md
# Fractional Phase-Accumulator Clock Generator

This block produces several programmable square-wave clocks from one core clock. Each generator holds a 32-bit increment and adds it to a 32-bit phase accumulator on every core clock cycle. The accumulator's top bit is registered and driven out as the generated clock. The output frequency is the core frequency times the increment divided by 2^32.

Software loads an increment through a single write port: an index that selects a generator, a data word and a strobe. An increment of zero stops that generator and sets its phase to zero. An increment larger than half scale is limited to 2^31-1, so no generated clock runs faster than half the core clock.

Top module: `frac_clkgen`

## Requirements
- R1: After reset every increment register, accumulator and clock output is 0.
- R2: A write with `wr_en_i` high loads `wr_data_i` into the increment of the generator selected by `wr_idx_i` (0..NUM_GEN-1). Generators that are not selected keep their increment and phase.
- R3: A write value above 2^31-1 is stored as 2^31-1.
- R4: A nonzero write takes effect at the next clock edge after the write edge. The accumulator keeps its phase and is not reloaded.
- R5: Writing 0 sets that generator's increment, accumulator and clock output to 0 at the write edge. The output then stays 0 until a nonzero increment is written.
- R6: On every edge with a nonzero increment, the accumulator advances by the increment modulo 2^32.
- R7: `clk_o[g]` equals bit 31 of generator g's accumulator as it stood one edge earlier. Over 2^32/N cycles (N a power of two) the output completes exactly one period and is high for half of it.
- R8: Because the increment is clamped, `clk_o[g]` never holds the same value on two consecutive edges less often than the phase allows: it toggles at most once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Increment write strobe |
| wr_idx_i | input | IDX_W | Index of the generator to write |
| wr_data_i | input | ACC_W | Increment value |
| clk_o | output | NUM_GEN | Generated clocks, one bit per generator |

## Verification
The bench runs a cycle-accurate arithmetic model of each generator and compares every output bit on every cycle during sweeps over several increments. These include 1, powers of two, odd values and the maximum 2^31-1.

It writes values above half scale and checks that they are clamped. A design that skipped the clamp would run faster than the limit and would drift from the model within a few cycles.

It changes the increment in the middle of a run. A design that reloaded the phase there would show a phase jump at the output.

It writes zero to one generator while the others keep running. A design that left the phase in place would restart from an arbitrary phase. A design that decoded the index wrongly would disturb a neighbouring generator.

// File: rtl/frac_clkgen_pkg.sv
package frac_clkgen_pkg;
  localparam int unsigned ACC_W = 32;
  typedef logic [ACC_W-1:0] phase_t;
  localparam phase_t INC_MAX = phase_t'({1'b0, {(ACC_W-1){1'b1}}});

  function automatic phase_t clamp_inc(input phase_t v);
    return (v > INC_MAX) ? INC_MAX : v;
  endfunction
endpackage

// File: rtl/frac_clkgen_chan.sv
module frac_clkgen_chan
  import frac_clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  phase_t inc_i,
  output logic   clk_o
);
  phase_t inc_q, acc_q;
  logic   stop_w;

  assign stop_w = load_i && (inc_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= '0;
      acc_q <= '0;
      clk_o <= 1'b0;
    end else if (stop_w) begin
      inc_q <= '0;
      acc_q <= '0;
      clk_o <= 1'b0;
    end else begin
      if (load_i) inc_q <= clamp_inc(inc_i);
      acc_q <= acc_q + inc_q;
      clk_o <= acc_q[ACC_W-1];
    end
  end

  assert_inc_clamped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q <= INC_MAX);
  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (acc_q == '0) && !clk_o);
  assert_idle_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_q == '0 && !load_i) |=> $stable(acc_q));
  assert_phase_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_w |=> acc_q == $past(acc_q) + $past(inc_q));
endmodule

// File: rtl/frac_clkgen_wdec.sv
module frac_clkgen_wdec #(
  parameter int unsigned NUM_GEN = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  output logic [NUM_GEN-1:0] load_o
);
  always_comb begin
    load_o = '0;
    for (int g = 0; g < NUM_GEN; g++)
      if (wr_en_i && (wr_idx_i == IDX_W'(g))) load_o[g] = 1'b1;
  end

  always_comb assert_one_load_R2: assert ($onehot0(load_o));
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
  import frac_clkgen_pkg::*;
#(
  parameter int unsigned NUM_GEN = 4,
  localparam int unsigned IDX_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ACC_W-1:0]   wr_data_i,
  output logic [NUM_GEN-1:0] clk_o
);
  logic [NUM_GEN-1:0] load_w;

  frac_clkgen_wdec #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_wdec (
    .wr_en_i (wr_en_i),
    .wr_idx_i(wr_idx_i),
    .load_o  (load_w)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    frac_clkgen_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load_w[g]),
      .inc_i (wr_data_i),
      .clk_o (clk_o[g])
    );
  end
endmodule

// File: tb/sim_frac_clkgen.sv
module sim_frac_clkgen;
  localparam int NG = 4;
  logic clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [1:0] wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [NG-1:0] clk_o;

  int checks = 0, errors = 0;
  logic [31:0] m_inc [NG];
  logic [31:0] m_acc [NG];
  logic [NG-1:0] m_out;
  bit model_on = 0;

  frac_clkgen u0 (.*);

  always #2.5 clk_i = ~clk_i;

  // Model: update on the same edge the design does, with the same write inputs.
  always @(posedge clk_i) if (model_on) begin
    for (int g = 0; g < NG; g++) begin
      if (wr_en_i && wr_idx_i == g && wr_data_i == 0) begin
        m_inc[g] = 0; m_acc[g] = 0; m_out[g] = 0;
      end else begin
        m_out[g] = m_acc[g][31];
        m_acc[g] = m_acc[g] + m_inc[g];
        if (wr_en_i && wr_idx_i == g)
          m_inc[g] = (wr_data_i > 32'h7FFF_FFFF) ? 32'h7FFF_FFFF : wr_data_i;
      end
    end
  end

  task automatic chk(input string req, input logic [NG-1:0] act, input logic [NG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clk_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en_i = 1; wr_idx_i = 2'(idx); wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      chk(req, clk_o, m_out);
    end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_inc[g] = 0; m_acc[g] = 0; end
    m_out = '0;
    #1; chk("R1 async reset", clk_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1; model_on = 1;
    run(10, "R1 idle after reset");

    // R2/R7: powers of two, with exact periods.
    wr(0, 32'h4000_0000);
    chk("R4 write edge", clk_o, m_out);
    wr(1, 32'h2000_0000);
    wr(2, 32'h0800_0000);
    run(200, "R7 power-of-two periods");

    // R3: clamp over half scale, including all ones.
    wr(3, 32'hFFFF_FFFF);
    run(40, "R3 clamp all-ones");
    wr(3, 32'h8000_0000);
    run(40, "R3 clamp half-scale");

    // R8: odd increments and the maximum.
    wr(0, 32'h7FFF_FFFF);
    wr(1, 32'h1234_5677);
    wr(2, 32'h0000_0001);
    run(300, "R8 odd increments");

    // R4: change N mid-run, phase kept.
    wr(1, 32'h3333_3333);
    run(100, "R4 retune keeps phase");

    // R5: stop one generator; others continue.
    wr(1, 32'h0);
    chk("R5 stop at write edge", clk_o, m_out);
    run(50, "R5 stopped stays low");
    chk("R5 output low", clk_o[1], 1'b0);
    wr(1, 32'h4000_0000);
    run(60, "R5 restart from zero phase");

    // R2: sweep a range of increments on every index.
    for (int k = 1; k <= 16; k++) begin
      wr(k % NG, 32'h0100_0000 * k + k);
      run(64, "R2 sweep");
    end
    wr(2, 32'h0);
    run(20, "R6 stop then idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule